// File: doc/BRIEF.md
# Vector Memory Element Address Sequencer

This block turns one vector load or store instruction into a stream of per-element memory requests. A one-cycle `start` pulse presents a base address, a second operand that acts as a length limit or a stride, an element size and a set of mode flags. The sequencer then walks every element position of the one or four vector registers the instruction covers, one position per accepted handshake. Each request carries the element address, an enable, the register index within the group and the element index within the register. Loads also mark positions beyond the length limit for zero fill. When the walk ends, a `done` pulse is raised. The updated base-register value comes with it when the instruction asks for post-increment.

An illegal combination of flags, an element-size code of 3, or a store stride that is too small makes the block raise `err` in the cycle after `start`. It then issues nothing and produces no write-back. The memory, the vector data path and the register file sit outside the block.

The controller has four states. `S_IDLE` waits for `start`. It moves to `S_FAULT` when the request is illegal and to `S_ISSUE` otherwise. `S_FAULT` lasts one cycle and returns to `S_IDLE`. `S_ISSUE` stays until the handshake of the last element position and then moves to `S_DONE`. `S_DONE` lasts one cycle and returns to `S_IDLE`.

Top module: `vec_mem_addr_seq`

## Requirements
- R1: After reset the block is idle: `req_valid`, `done`, `err`, `wb_valid` and `busy` are all 0.
- R2: `elem_size` 0, 1 and 2 select 1-, 2- and 4-byte elements. Elements per register is E = (VLEN_BITS/8) / bytes. A legal instruction issues exactly R×E requests, where R is 4 when `m_multi`=1 and 1 otherwise. `req_reg` counts 0..R-1 and, inside each register, `req_elem` counts 0..E-1 in order.
- R3: Without stride, an enabled element e of a register is addressed at that register's base plus e×bytes. The next register's base is the current base plus n×bytes, where n is the active count of the current register.
- R4: With `m_stride`=1 and `m_quad`=0, each register's base is the previous register's base plus `operand`×bytes.
- R5: The total count C is R×E. With `m_len`=1, C is min(R×E, `operand`). A register's active count n is min(E, elements remaining). On loads (`m_load`=1), positions e≥n have `req_en`=0 and `req_zero`=1. Positions e<n have `req_en`=1 and `req_zero`=0.
- R6: On stores, `req_we`=1 for every request, positions e≥n have `req_en`=0, and `req_zero` is never 1.
- R7: A quad store splits each register into four quarters of E/4 elements. Element e of quarter i is addressed at the register base plus i×`operand`×bytes plus e×bytes. The next register starts 4×`operand`×bytes later.
- R8: `wb_valid` rises with `done` only when `m_post`=1 and C≠0. `wb_addr` is base plus an increment chosen by form: length and stride gives VLEN_BITS/8; single form with neither gives (VLEN_BITS/8)×R; length only gives C×bytes; stride only gives `operand`×bytes×R, ×4 for quad; two-operand with neither gives `operand`×bytes.
- R9: Illegal cases raise `err` for one cycle in the cycle after `start`. No request, `done` or write-back follows. The illegal cases are: single form with length or stride; two-operand form with no length, no stride and no post-increment; length and stride without post-increment; quad on a load; quad without stride or with length; `elem_size`=3.
- R10: A non-quad store with stride and `operand` < E is illegal. A quad store with `operand` < E/4 is illegal.
- R11: While `req_valid`=1 and `req_ready`=0, the request is held unchanged into the next cycle.
- R12: A `start` pulse while `busy`=1 has no effect on the running sequence.
- R13: Address and write-back arithmetic is modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (only sampled when idle) |
| base_addr | input | ADDR_W | Base address register value |
| operand | input | ADDR_W | Length limit or stride, in elements |
| elem_size | input | 2 | 0 byte, 1 halfword, 2 word |
| m_len | input | 1 | Length limit applies |
| m_stride | input | 1 | Stride applies |
| m_post | input | 1 | Post-increment the base |
| m_single | input | 1 | Single-operand form (operand unused) |
| m_multi | input | 1 | Cover four registers instead of one |
| m_quad | input | 1 | Quarter-strided store |
| m_load | input | 1 | 1 load, 0 store |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W | Element byte address |
| req_en | output | 1 | Element is accessed |
| req_we | output | 1 | Store request |
| req_zero | output | 1 | Load position to be zero-filled |
| req_reg | output | 2 | Register index inside the group |
| req_elem | output | log2(VLEN_BITS/8) | Element index inside the register |
| done | output | 1 | Sequence finished (one cycle) |
| err | output | 1 | Illegal request (one cycle) |
| wb_valid | output | 1 | Base write-back present |
| wb_addr | output | ADDR_W | Updated base value |
| busy | output | 1 | Not idle |

## Verification
The hardest situation to reach is a length-limited, strided, multi-register walk under back-pressure. In that case the active count drops to a partial value and then to zero midway through the group, while the register base keeps moving by the stride and not by the active count. The stimulus combines a length that ends inside the second register with a stride larger than one register and a recurring ready gap. It also pulses `start` with conflicting operands in the middle of a walk. Every request is compared each cycle against a queue built behaviourally from the requirements.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } elem_sz_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FAULT = 2'd1,
        S_ISSUE = 2'd2,
        S_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic len;
        logic stride;
        logic post;
        logic single;
        logic multi;
        logic quad;
        logic load;
    } mode_t;

endpackage

// File: rtl/vseq_decode.sv
module vseq_decode
    import vseq_pkg::*;
#(
    parameter int VLEN_BITS = 256,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 8
) (
    input  mode_t             mode,
    input  logic [1:0]        esz,
    input  logic [ADDR_W-1:0] operand,
    output logic              illegal,
    output logic [CNT_W-1:0]  epr,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] incr,
    output logic [ADDR_W-1:0] stride_bytes
);
    localparam int VLEN_BYTES = VLEN_BITS / 8;

    logic [CNT_W-1:0]  total;
    logic [CNT_W-1:0]  quarter;
    logic [2:0]        stride_sh;
    logic              form_bad;
    logic              stride_small;

    always_comb begin
        epr     = CNT_W'(VLEN_BYTES) >> esz;
        quarter = epr >> 2;
        total   = mode.multi ? (epr << 2) : epr;
        if (mode.len && (operand < ADDR_W'(total)))
            count = CNT_W'(operand);
        else
            count = total;
        stride_bytes = operand << esz;
    end

    always_comb begin
        form_bad = 1'b0;
        if (mode.single && (mode.len || mode.stride))
            form_bad = 1'b1;
        if (!mode.single && !mode.len && !mode.stride && !mode.post)
            form_bad = 1'b1;
        if (mode.len && mode.stride && !mode.post)
            form_bad = 1'b1;
        if (mode.quad && (mode.load || !mode.stride || mode.len))
            form_bad = 1'b1;
        if (esz == SZ_BAD)
            form_bad = 1'b1;

        stride_small = 1'b0;
        if (!mode.load && mode.stride && !mode.quad && (operand < ADDR_W'(epr)))
            stride_small = 1'b1;
        if (mode.quad && (operand < ADDR_W'(quarter)))
            stride_small = 1'b1;

        illegal = form_bad || stride_small;
    end

    always_comb begin
        stride_sh = 3'(esz) + (mode.multi ? 3'd2 : 3'd0) + (mode.quad ? 3'd2 : 3'd0);
        if (mode.len && mode.stride)
            incr = ADDR_W'(VLEN_BYTES);
        else if (mode.single && !mode.len && !mode.stride)
            incr = ADDR_W'(VLEN_BYTES) << (mode.multi ? 2 : 0);
        else if (mode.len)
            incr = ADDR_W'(count) << esz;
        else if (mode.stride)
            incr = operand << stride_sh;
        else
            incr = operand << esz;
    end

endmodule

// File: rtl/vseq_walk.sv
module vseq_walk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_base,
    input  logic [CNT_W-1:0]  load_count,
    input  logic              step,
    input  logic [1:0]        esz,
    input  logic              multi,
    input  logic              quad,
    input  logic              strided,
    input  logic [CNT_W-1:0]  epr,
    input  logic [ADDR_W-1:0] stride_bytes,
    output logic [ADDR_W-1:0] addr,
    output logic              active,
    output logic [1:0]        reg_idx,
    output logic [IDX_W-1:0]  elem_idx,
    output logic              last
);
    logic [ADDR_W-1:0] reg_base;
    logic [ADDR_W-1:0] quad_off;
    logic [CNT_W-1:0]  left;
    logic [CNT_W-1:0]  n_act;
    logic [CNT_W-1:0]  elem_w;
    logic [CNT_W-1:0]  qmask;
    logic              last_elem;
    logic              last_reg;
    logic              quarter_end;
    logic [ADDR_W-1:0] reg_step;

    always_comb begin
        elem_w      = CNT_W'(elem_idx);
        n_act       = (left < epr) ? left : epr;
        active      = elem_w < n_act;
        last_elem   = elem_w == (epr - CNT_W'(1));
        last_reg    = reg_idx == (multi ? 2'd3 : 2'd0);
        last        = last_elem && last_reg;
        qmask       = (epr >> 2) - CNT_W'(1);
        quarter_end = ((elem_w + CNT_W'(1)) & qmask) == '0;
        addr        = reg_base + quad_off + (ADDR_W'(elem_idx) << esz);
        if (quad)
            reg_step = stride_bytes << 2;
        else if (strided)
            reg_step = stride_bytes;
        else
            reg_step = ADDR_W'(n_act) << esz;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_base <= '0;
            quad_off <= '0;
            left     <= '0;
            reg_idx  <= '0;
            elem_idx <= '0;
        end else if (load_en) begin
            reg_base <= load_base;
            quad_off <= '0;
            left     <= load_count;
            reg_idx  <= '0;
            elem_idx <= '0;
        end else if (step) begin
            if (last_elem) begin
                elem_idx <= '0;
                quad_off <= '0;
                reg_idx  <= reg_idx + 2'd1;
                left     <= left - n_act;
                reg_base <= reg_base + reg_step;
            end else begin
                elem_idx <= elem_idx + IDX_W'(1);
                if (quad && quarter_end)
                    quad_off <= quad_off + stride_bytes;
            end
        end
    end

endmodule

// File: rtl/vec_mem_addr_seq.sv
module vec_mem_addr_seq
    import vseq_pkg::*;
#(
    parameter int VLEN_BITS = 256,
    parameter int ADDR_W    = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [ADDR_W-1:0]                 base_addr,
    input  logic [ADDR_W-1:0]                 operand,
    input  logic [1:0]                        elem_size,
    input  logic                              m_len,
    input  logic                              m_stride,
    input  logic                              m_post,
    input  logic                              m_single,
    input  logic                              m_multi,
    input  logic                              m_quad,
    input  logic                              m_load,
    output logic                              req_valid,
    input  logic                              req_ready,
    output logic [ADDR_W-1:0]                 req_addr,
    output logic                              req_en,
    output logic                              req_we,
    output logic                              req_zero,
    output logic [1:0]                        req_reg,
    output logic [$clog2(VLEN_BITS/8)-1:0]    req_elem,
    output logic                              done,
    output logic                              err,
    output logic                              wb_valid,
    output logic [ADDR_W-1:0]                 wb_addr,
    output logic                              busy
);
    localparam int VLEN_BYTES = VLEN_BITS / 8;
    localparam int IDX_W      = $clog2(VLEN_BYTES);
    localparam int CNT_W      = $clog2(4 * VLEN_BYTES + 1);

    seq_state_e        state, state_nx;
    mode_t             mode_in;
    logic              illegal;
    logic [CNT_W-1:0]  dec_epr, dec_count;
    logic [ADDR_W-1:0] dec_incr, dec_stride;

    logic              q_multi, q_quad, q_stride, q_load, q_wb_en;
    logic [1:0]        q_esz;
    logic [CNT_W-1:0]  q_epr;
    logic [ADDR_W-1:0] q_stride_b, q_wb;

    logic              accept, step;
    logic [ADDR_W-1:0] w_addr;
    logic              w_active, w_last;
    logic [1:0]        w_reg;
    logic [IDX_W-1:0]  w_elem;

    assign mode_in = '{len: m_len, stride: m_stride, post: m_post, single: m_single,
                       multi: m_multi, quad: m_quad, load: m_load};

    vseq_decode #(.VLEN_BITS(VLEN_BITS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
        .mode         (mode_in),
        .esz          (elem_size),
        .operand      (operand),
        .illegal      (illegal),
        .epr          (dec_epr),
        .count        (dec_count),
        .incr         (dec_incr),
        .stride_bytes (dec_stride)
    );

    assign accept = (state == S_IDLE) && start && !illegal;
    assign step   = (state == S_ISSUE) && req_ready;

    vseq_walk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_en      (accept),
        .load_base    (base_addr),
        .load_count   (dec_count),
        .step         (step),
        .esz          (q_esz),
        .multi        (q_multi),
        .quad         (q_quad),
        .strided      (q_stride),
        .epr          (q_epr),
        .stride_bytes (q_stride_b),
        .addr         (w_addr),
        .active       (w_active),
        .reg_idx      (w_reg),
        .elem_idx     (w_elem),
        .last         (w_last)
    );

    // Configuration captured when a legal request is taken.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_multi    <= 1'b0;
            q_quad     <= 1'b0;
            q_stride   <= 1'b0;
            q_load     <= 1'b0;
            q_wb_en    <= 1'b0;
            q_esz      <= 2'd0;
            q_epr      <= '0;
            q_stride_b <= '0;
            q_wb       <= '0;
        end else if (accept) begin
            q_multi    <= m_multi;
            q_quad     <= m_quad;
            q_stride   <= m_stride;
            q_load     <= m_load;
            q_wb_en    <= m_post && (dec_count != '0);
            q_esz      <= elem_size;
            q_epr      <= dec_epr;
            q_stride_b <= dec_stride;
            q_wb       <= base_addr + dec_incr;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // Transitions.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = illegal ? S_FAULT : S_ISSUE;
            S_FAULT: state_nx = S_IDLE;
            S_ISSUE: if (req_ready && w_last) state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        req_valid = 1'b0;
        req_en    = 1'b0;
        req_we    = 1'b0;
        req_zero  = 1'b0;
        done      = 1'b0;
        err       = 1'b0;
        wb_valid  = 1'b0;
        busy      = 1'b1;
        unique case (state)
            S_IDLE:  busy = 1'b0;
            S_FAULT: err  = 1'b1;
            S_ISSUE: begin
                req_valid = 1'b1;
                req_en    = w_active;
                req_we    = !q_load;
                req_zero  = q_load && !w_active;
            end
            S_DONE: begin
                done     = 1'b1;
                wb_valid = q_wb_en;
            end
            default: busy = 1'b0;
        endcase
        req_addr = w_addr;
        req_reg  = w_reg;
        req_elem = w_elem;
        wb_addr  = q_wb;
    end

endmodule

// File: rtl/vseq_check.sv
module vseq_check #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_en,
    input logic              req_we,
    input logic              req_zero,
    input logic              done,
    input logic              err,
    input logic              wb_valid,
    input logic              busy
);
    // R11: a stalled request stays put
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));

    // R5 / R6: zero fill only on inactive load positions
    a_r5_zero_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        req_zero |-> !req_en && !req_we);

    // R9: a fault issues nothing and does not finish
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !req_valid && !done && !wb_valid);

    // R9: a fault only follows a start
    a_r9_err_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(start));

    // R8: write-back only comes with done
    a_r8_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done);

    // R2: request, completion and fault are exclusive
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_valid, done, err}));

    // R12: after completion the block is idle again
    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

bind vec_mem_addr_seq vseq_check #(.ADDR_W(ADDR_W)) u_vseq_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_en    (req_en),
    .req_we    (req_we),
    .req_zero  (req_zero),
    .done      (done),
    .err       (err),
    .wb_valid  (wb_valid),
    .busy      (busy)
);

// File: tb/vec_mem_addr_seq_test.sv
module vec_mem_addr_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int VB = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0, operand = '0;
    logic [1:0]  elem_size = '0;
    logic        m_len = 0, m_stride = 0, m_post = 0, m_single = 0, m_multi = 0, m_quad = 0, m_load = 0;
    logic        req_valid, req_ready = 1'b0;
    logic [31:0] req_addr;
    logic        req_en, req_we, req_zero;
    logic [1:0]  req_reg;
    logic [4:0]  req_elem;
    logic        done, err, wb_valid, busy;
    logic [31:0] wb_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_mem_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .operand(operand),
        .elem_size(elem_size), .m_len(m_len), .m_stride(m_stride), .m_post(m_post),
        .m_single(m_single), .m_multi(m_multi), .m_quad(m_quad), .m_load(m_load),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_en(req_en),
        .req_we(req_we), .req_zero(req_zero), .req_reg(req_reg), .req_elem(req_elem),
        .done(done), .err(err), .wb_valid(wb_valid), .wb_addr(wb_addr), .busy(busy)
    );

    // expected request stream
    logic [31:0] qa[$];
    bit          qen[$], qz[$], qwe[$];
    int          qr[$], qe[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [31:0] base, input logic [31:0] op,
                          input logic [1:0] es, input bit l, input bit s, input bit p,
                          input bit sg, input bit mu, input bit qd, input bit ld,
                          input bit stall, input bit poke);
        int bytes, epr, regs, total, cnt, left, n, quar;
        bit bad, exp_wbv;
        logic [31:0] run, exp_wb, inc;
        bit finished;
        int cyc;
        qa.delete(); qen.delete(); qz.delete(); qwe.delete(); qr.delete(); qe.delete();
        bytes = 1 << es;
        epr   = VB / bytes;
        regs  = mu ? 4 : 1;
        total = regs * epr;
        cnt   = (l && op < total) ? int'(op) : total;
        quar  = epr / 4;
        bad = (es == 2'd3) || (sg && (l || s)) || (!sg && !l && !s && !p) || (l && s && !p)
              || (qd && ld) || (qd && (!s || l))
              || (!ld && s && !qd && op < epr) || (qd && op < quar);
        run = base;
        left = cnt;
        for (int r = 0; r < regs; r++) begin
            n = (left < epr) ? left : epr;
            for (int e = 0; e < epr; e++) begin
                if (qd) qa.push_back(run + (e / quar) * op * bytes + e * bytes);
                else    qa.push_back(run + e * bytes);
                qen.push_back(e < n);
                qz.push_back(ld && e >= n);
                qwe.push_back(!ld);
                qr.push_back(r);
                qe.push_back(e);
            end
            left -= n;
            if (qd)      run = run + 4 * op * bytes;
            else if (s)  run = run + op * bytes;
            else         run = run + n * bytes;
        end
        if (l && s)            inc = VB;
        else if (sg && !l && !s) inc = VB * regs;
        else if (l)            inc = cnt * bytes;
        else if (s)            inc = op * bytes * regs * (qd ? 4 : 1);
        else                   inc = op * bytes;
        exp_wbv = p && cnt != 0;
        exp_wb  = base + inc;

        @(negedge clk);
        base_addr = base; operand = op; elem_size = es;
        m_len = l; m_stride = s; m_post = p; m_single = sg; m_multi = mu; m_quad = qd; m_load = ld;
        start = 1'b1;
        req_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (bad) begin
            chk(err === 1'b1 && req_valid === 1'b0, tag, "err after start", err, 1);
            @(negedge clk);
            chk(err === 1'b0 && req_valid === 1'b0 && done === 1'b0 && busy === 1'b0,
                tag, "idle after fault", {err, req_valid, done, busy}, 0);
            return;
        end
        finished = 0;
        cyc = 0;
        while (!finished && cyc < 3000) begin
            start = 1'b0;
            if (done) begin
                chk(qa.size() == 0, tag, "requests left at done", qa.size(), 0);
                chk(wb_valid === exp_wbv, tag, "wb_valid (R8)", wb_valid, exp_wbv);
                if (exp_wbv) chk(wb_addr === exp_wb, tag, "wb_addr (R8)", wb_addr, exp_wb);
                finished = 1;
            end else if (!req_valid) begin
                chk(0, tag, "req_valid low while issuing", 0, 1);
            end else if (qa.size() == 0) begin
                chk(0, tag, "extra request", req_addr, 0);
            end else begin
                chk(req_en === qen[0] && req_zero === qz[0] && req_we === qwe[0]
                    && req_reg === 2'(qr[0]) && req_elem === 5'(qe[0])
                    && (!qen[0] || req_addr === qa[0]),
                    tag, $sformatf("req r%0d e%0d en/zero/we/reg/elem/addr", qr[0], qe[0]),
                    {req_en, req_zero, req_we, req_reg, req_elem, req_addr},
                    {qen[0], qz[0], qwe[0], 2'(qr[0]), 5'(qe[0]), qen[0] ? qa[0] : req_addr});
                req_ready = stall ? (cyc % 3 != 1) : 1'b1;
                if (req_ready) begin
                    qa.pop_front(); qen.pop_front(); qz.pop_front(); qwe.pop_front();
                    qr.pop_front(); qe.pop_front();
                end
                if (poke && cyc == 2) begin
                    // R12: conflicting start while busy
                    start = 1'b1; base_addr = 32'hDEAD_0000; operand = 32'd1;
                    m_load = 1'b1; m_quad = 1'b1; elem_size = 2'd3;
                end
            end
            if (!finished) begin
                @(negedge clk);
                cyc++;
            end
        end
        start = 1'b0;
        if (!finished) chk(0, tag, "sequence did not finish", cyc, 0);
        @(negedge clk);
        chk(busy === 1'b0, tag, "idle after done", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(req_valid === 0 && done === 0 && err === 0 && wb_valid === 0 && busy === 0,
            "R1", "reset state", {req_valid, done, err, wb_valid, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 0 && req_valid === 0, "R1", "idle after reset", busy, 0);

        // args: base op es len str post single multi quad load stall poke
        run_op("R2 R3 byte load", 32'h0000_1000, 0, 2'd0, 0,0,0,1,0,0,1, 0,0);
        run_op("R2 R8 word load multi post", 32'h0000_2000, 0, 2'd2, 0,0,1,1,1,0,1, 0,0);
        run_op("R5 R8 half load len", 32'h0000_3000, 5, 2'd1, 1,0,1,0,0,0,1, 0,0);
        run_op("R5 R8 len zero", 32'h0000_3100, 0, 2'd0, 1,0,1,0,1,0,1, 0,0);
        run_op("R4 R6 R8 half store stride", 32'h0000_4000, 16, 2'd1, 0,1,1,0,1,0,0, 0,0);
        run_op("R6 R8 word store len", 32'h0000_5000, 20, 2'd2, 1,0,1,0,1,0,0, 0,0);
        run_op("R7 R8 R11 quad store", 32'h0000_6000, 8, 2'd0, 0,1,1,0,1,1,0, 1,0);
        run_op("R4 R5 R8 R11 len stride", 32'h0000_7000, 20, 2'd1, 1,1,1,0,1,0,1, 1,0);
        run_op("R3 R8 two-operand post", 32'h0000_8000, 7, 2'd0, 0,0,1,0,0,0,1, 0,0);
        run_op("R13 wrap", 32'hFFFF_FFF0, 0, 2'd0, 0,0,1,1,0,0,1, 0,0);
        run_op("R12 busy start", 32'h0000_9000, 0, 2'd1, 0,0,0,1,1,0,1, 1,1);
        run_op("R9 single with len", 32'h0, 4, 2'd0, 1,0,0,1,0,0,1, 0,0);
        run_op("R9 quad load", 32'h0, 8, 2'd0, 0,1,0,0,0,1,1, 0,0);
        run_op("R9 len stride no post", 32'h0, 8, 2'd0, 1,1,0,0,0,0,1, 0,0);
        run_op("R9 two-operand bare", 32'h0, 8, 2'd0, 0,0,0,0,0,0,1, 0,0);
        run_op("R9 size code 3", 32'h0, 0, 2'd3, 0,0,0,1,0,0,1, 0,0);
        run_op("R10 store stride small", 32'h0, 15, 2'd1, 0,1,0,0,0,0,0, 0,0);
        run_op("R10 quad stride small", 32'h0, 7, 2'd0, 0,1,0,0,0,1,0, 0,0);
        run_op("R10 store stride at limit", 32'h0000_A000, 8, 2'd2, 0,1,0,0,0,0,0, 0,0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule